// File: doc/BRIEF.md
# Protected EEPROM Page Programmer

This block is a host-side controller for a byte-wide parallel EEPROM that only accepts writes after an unlock command. It programs one page per request. Software first fills a local page buffer through a byte-write port. It then pulses `start` with a page number, a byte count and a completion-detection mode.

The controller always writes the three unlock bytes first. It then writes buffer slots 0 to count-1 to consecutive offsets of the selected page, and after that polls the device until the internal program cycle ends.

All bus strobes are active low and come from registers. Pulse widths, recovery times and read access times are set as whole clock cycles through parameters. A poll that never completes is abandoned after a programmable number of cycles. A request with an unusable byte count finishes at once and leaves the bus untouched.

Top module: `eeprom_page_prog`

## Requirements
- R1: Every accepted request begins with exactly three write pulses, in this order: data AA at address 5555, data 55 at address 2AAA, then data A0 at address 5555 (hexadecimal values).
- R2: After the unlock writes, the controller makes exactly `byte_count` writes. Write k (counting from 0) carries buffer slot k and goes to address {page, k}, where the page number occupies the upper address bits and k the low 6 bits.
- R3: The upper address bits (14:6) are the same on every write pulse after the unlock sequence of a request.
- R4: `we_n` stays low for at least WP_CYC cycles and high for at least WPH_CYC cycles between pulses. While `we_n` is low, `oe_n` is high, `ce_n` is low, `dq_oe` is 1, and `addr` and `dq_out` do not change.
- R5: The interval between the falling edges of consecutive write pulses within one request is shorter than BLC_CYC cycles.
- R6: With `poll_mode` = 0 (data polling), the controller reads address {page, count-1} repeatedly. It pulses `done` after the first read that returns exactly the last byte written; a complemented bit 7 keeps it polling.
- R7: With `poll_mode` = 1 (toggle detection), the controller reads that same fixed address. It pulses `done` once bit 6 holds the same value on two successive reads. `oe_n` stays high for at least OEH_CYC cycles between reads.
- R8: If polling has not completed after POLL_LIMIT cycles, the controller pulses `timeout` instead of `done`. The pulse comes no sooner than POLL_LIMIT cycles after polling starts and at most one read cycle later, and the bus is then idle.
- R9: A `byte_count` of 0 or greater than PAGE_BYTES produces a `done` pulse within two cycles and no write or read on the bus.
- R10: A `start` pulse that arrives while a request is in progress is ignored. The running request finishes unchanged and produces a single `done`.
- R11: While `rst` is high, `ce_n`, `oe_n` and `we_n` are 1, and `dq_oe`, `done` and `timeout` are 0.
- R12: `done` and `timeout` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled while idle |
| page | input | 9 | Target page number (address bits 14:6) |
| byte_count | input | 7 | Number of bytes to program, 1..64 |
| poll_mode | input | 1 | 0 = data polling, 1 = toggle detection |
| buf_we | input | 1 | Page buffer write enable |
| buf_idx | input | 6 | Page buffer slot to write |
| buf_wdata | input | 8 | Byte written into the page buffer |
| done | output | 1 | Request finished (pulse) |
| timeout | output | 1 | Polling abandoned (pulse) |
| ce_n | output | 1 | Device select, active low |
| oe_n | output | 1 | Device output enable, active low |
| we_n | output | 1 | Device write strobe, active low |
| addr | output | 15 | Device address |
| dq_out | output | 8 | Data driven to the device |
| dq_oe | output | 1 | Enables the data bus driver |
| dq_in | input | 8 | Data returned by the device |

## Verification
The bound checker watches the bus strobes on every cycle. It checks the unlock bytes and their order, the minimum low and high widths of the write strobe, the read recovery gap, and that address and data hold still during a pulse. It also checks the write spacing against the byte-load window, the fixed page bits on data writes, the strobe state during reset, and that the two completion pulses stay separate.

Only the bench scenarios, run against a behavioural device that reports busy status, can show that the right buffer bytes reach the right offsets. They also show that each polling mode finishes only after the device is ready, that a hung device produces the timeout, and that a bad byte count or a mid-request start leaves the bus alone.

// File: rtl/eepg_pkg.sv
package eepg_pkg;

  typedef enum logic {
    POLL_DATA   = 1'b0,
    POLL_TOGGLE = 1'b1
  } poll_mode_e;

  typedef enum logic [1:0] {
    CY_IDLE,
    CY_ACT,
    CY_REC
  } cyc_st_e;

  typedef enum logic [2:0] {
    PG_IDLE,
    PG_CMD_GO,
    PG_CMD_WAIT,
    PG_FETCH,
    PG_BYTE_GO,
    PG_BYTE_WAIT,
    PG_POLL_GO,
    PG_POLL_WAIT
  } prog_st_e;

endpackage

// File: rtl/eepg_page_buf.sv
module eepg_page_buf #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port memory with a registered read port
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/eepg_bus_cycle.sv
module eepg_bus_cycle
  import eepg_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int WP_CYC  = 10,
  parameter int WPH_CYC = 5,
  parameter int RD_CYC  = 10,
  parameter int OEH_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_write,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_data,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  localparam int T_A   = (WP_CYC > RD_CYC) ? WP_CYC : RD_CYC;
  localparam int T_B   = (WPH_CYC > OEH_CYC) ? WPH_CYC : OEH_CYC;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CT_W  = $clog2(T_MAX + 1);

  localparam logic [CT_W-1:0] WP_L  = CT_W'(WP_CYC - 1);
  localparam logic [CT_W-1:0] WPH_L = CT_W'(WPH_CYC - 1);
  localparam logic [CT_W-1:0] RD_L  = CT_W'(RD_CYC - 1);
  localparam logic [CT_W-1:0] OEH_L = CT_W'(OEH_CYC - 1);

  cyc_st_e         st;
  logic [CT_W-1:0] cnt;
  logic            is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= CY_IDLE;
      cnt    <= '0;
      is_wr  <= 1'b0;
      ack    <= 1'b0;
      rdata  <= '0;
      ce_n   <= 1'b1;
      oe_n   <= 1'b1;
      we_n   <= 1'b1;
      addr   <= '0;
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (st)
        CY_IDLE: begin
          if (go) begin
            addr   <= go_addr;
            dq_out <= go_data;
            is_wr  <= go_write;
            ce_n   <= 1'b0;
            we_n   <= !go_write;
            oe_n   <= go_write;
            dq_oe  <= go_write;
            cnt    <= go_write ? WP_L : RD_L;
            st     <= CY_ACT;
          end
        end
        CY_ACT: begin
          if (cnt == '0) begin
            ce_n <= 1'b1;
            we_n <= 1'b1;
            oe_n <= 1'b1;
            if (!is_wr) rdata <= dq_in;
            cnt  <= is_wr ? WPH_L : OEH_L;
            st   <= CY_REC;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        CY_REC: begin
          if (cnt == '0) begin
            dq_oe <= 1'b0;
            ack   <= 1'b1;
            st    <= CY_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= CY_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eepg_poll_eval.sv
module eepg_poll_eval
  import eepg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp,
  input  logic [DATA_W-1:0] expect_byte,
  input  poll_mode_e        mode,
  output logic              hit
);

  localparam int TB = DATA_W - 2;

  logic have_prev;
  logic prev_tb;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      have_prev <= 1'b0;
      prev_tb   <= 1'b0;
    end else if (smp_vld) begin
      have_prev <= 1'b1;
      prev_tb   <= smp[TB];
    end
  end

  always_comb begin
    if (mode == POLL_DATA) hit = (smp == expect_byte);
    else                   hit = have_prev && (smp[TB] == prev_tb);
  end

endmodule

// File: rtl/eeprom_page_prog.sv
module eeprom_page_prog
  import eepg_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter int WP_CYC     = 10,
  parameter int WPH_CYC    = 5,
  parameter int RD_CYC     = 10,
  parameter int OEH_CYC    = 8,
  parameter int POLL_LIMIT = 600000,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = 15'h5555,
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = 15'h2AAA,
  localparam int OFS_W = $clog2(PAGE_BYTES),
  localparam int PG_W  = ADDR_W - OFS_W,
  localparam int CNT_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PG_W-1:0]   page,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              poll_mode,
  input  logic              buf_we,
  input  logic [OFS_W-1:0]  buf_idx,
  input  logic [DATA_W-1:0] buf_wdata,
  output logic              done,
  output logic              timeout,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  localparam int TMO_W = $clog2(POLL_LIMIT + 1);
  localparam logic [DATA_W-1:0] CMD_D0 = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] CMD_D1 = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] CMD_D2 = DATA_W'(8'hA0);

  prog_st_e          st;
  logic [1:0]        step;
  logic [OFS_W-1:0]  idx;
  logic [OFS_W-1:0]  last_idx;
  logic [CNT_W-1:0]  cnt_q;
  logic [PG_W-1:0]   page_q;
  poll_mode_e        mode_q;
  logic [DATA_W-1:0] last_byte;
  logic [TMO_W-1:0]  tmo;
  logic              poll_clr;

  logic              cyc_go;
  logic              cyc_wr;
  logic [ADDR_W-1:0] cyc_addr;
  logic [DATA_W-1:0] cyc_data;
  logic              cyc_ack;
  logic [DATA_W-1:0] cyc_rdata;
  logic [DATA_W-1:0] buf_rdata;
  logic              poll_hit;
  logic              poll_vld;

  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              cnt_bad;

  assign last_idx = OFS_W'(cnt_q - 1'b1);
  assign poll_vld = cyc_ack && (st == PG_POLL_WAIT);
  assign cnt_bad  = (byte_count == '0) || (byte_count > CNT_W'(PAGE_BYTES));

  always_comb begin
    case (step)
      2'd0:    begin cmd_addr = CMD_ADDR_A; cmd_data = CMD_D0; end
      2'd1:    begin cmd_addr = CMD_ADDR_B; cmd_data = CMD_D1; end
      default: begin cmd_addr = CMD_ADDR_A; cmd_data = CMD_D2; end
    endcase
  end

  eepg_page_buf #(
    .DEPTH (PAGE_BYTES),
    .DATA_W(DATA_W)
  ) u_buf (
    .clk    (clk),
    .wr_en  (buf_we),
    .wr_idx (buf_idx),
    .wr_data(buf_wdata),
    .rd_idx (idx),
    .rd_data(buf_rdata)
  );

  eepg_bus_cycle #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WP_CYC (WP_CYC),
    .WPH_CYC(WPH_CYC),
    .RD_CYC (RD_CYC),
    .OEH_CYC(OEH_CYC)
  ) u_cyc (
    .clk     (clk),
    .rst     (rst),
    .go      (cyc_go),
    .go_write(cyc_wr),
    .go_addr (cyc_addr),
    .go_data (cyc_data),
    .ack     (cyc_ack),
    .rdata   (cyc_rdata),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .addr    (addr),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe),
    .dq_in   (dq_in)
  );

  eepg_poll_eval #(
    .DATA_W(DATA_W)
  ) u_eval (
    .clk        (clk),
    .rst        (rst),
    .clr        (poll_clr),
    .smp_vld    (poll_vld),
    .smp        (cyc_rdata),
    .expect_byte(last_byte),
    .mode       (mode_q),
    .hit        (poll_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PG_IDLE;
      step      <= '0;
      idx       <= '0;
      cnt_q     <= '0;
      page_q    <= '0;
      mode_q    <= POLL_DATA;
      last_byte <= '0;
      tmo       <= '0;
      poll_clr  <= 1'b0;
      cyc_go    <= 1'b0;
      cyc_wr    <= 1'b0;
      cyc_addr  <= '0;
      cyc_data  <= '0;
      done      <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      cyc_go   <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      poll_clr <= 1'b0;
      if ((st == PG_POLL_GO || st == PG_POLL_WAIT) && (tmo < TMO_W'(POLL_LIMIT)))
        tmo <= tmo + 1'b1;
      case (st)
        PG_IDLE: begin
          if (start) begin
            if (cnt_bad) begin
              done <= 1'b1;
            end else begin
              page_q <= page;
              cnt_q  <= byte_count;
              mode_q <= poll_mode_e'(poll_mode);
              step   <= '0;
              st     <= PG_CMD_GO;
            end
          end
        end
        PG_CMD_GO: begin
          cyc_go   <= 1'b1;
          cyc_wr   <= 1'b1;
          cyc_addr <= cmd_addr;
          cyc_data <= cmd_data;
          st       <= PG_CMD_WAIT;
        end
        PG_CMD_WAIT: begin
          if (cyc_ack) begin
            if (step == 2'd2) begin
              idx <= '0;
              st  <= PG_FETCH;
            end else begin
              step <= step + 1'b1;
              st   <= PG_CMD_GO;
            end
          end
        end
        PG_FETCH: st <= PG_BYTE_GO;
        PG_BYTE_GO: begin
          cyc_go    <= 1'b1;
          cyc_wr    <= 1'b1;
          cyc_addr  <= {page_q, idx};
          cyc_data  <= buf_rdata;
          last_byte <= buf_rdata;
          st        <= PG_BYTE_WAIT;
        end
        PG_BYTE_WAIT: begin
          if (cyc_ack) begin
            if (idx == last_idx) begin
              poll_clr <= 1'b1;
              tmo      <= '0;
              st       <= PG_POLL_GO;
            end else begin
              idx <= idx + 1'b1;
              st  <= PG_FETCH;
            end
          end
        end
        PG_POLL_GO: begin
          cyc_go   <= 1'b1;
          cyc_wr   <= 1'b0;
          cyc_addr <= {page_q, last_idx};
          st       <= PG_POLL_WAIT;
        end
        PG_POLL_WAIT: begin
          if (cyc_ack) begin
            if (poll_hit) begin
              done <= 1'b1;
              st   <= PG_IDLE;
            end else if (tmo >= TMO_W'(POLL_LIMIT)) begin
              timeout <= 1'b1;
              st      <= PG_IDLE;
            end else begin
              st <= PG_POLL_GO;
            end
          end
        end
        default: st <= PG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eepg_chk.sv
module eepg_chk #(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int OFS_W   = 6,
  parameter int WP_CYC  = 10,
  parameter int WPH_CYC = 5,
  parameter int OEH_CYC = 8,
  parameter int BLC_CYC = 7500,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = 15'h5555,
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = 15'h2AAA
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              timeout,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);

  localparam int CK_W = $clog2(BLC_CYC + 2);
  localparam int PG_W = ADDR_W - OFS_W;
  localparam logic [CK_W-1:0] CK_MAX = '1;

  logic [7:0]      nwr;
  logic [CK_W-1:0] lo_cnt, hi_cnt, gap_cnt, oeh_cnt;
  logic            we_q, oe_q, rd_seen;
  logic [PG_W-1:0] pg_q;
  logic            we_fall, oe_fall, op_end;

  assign we_fall = we_q && !we_n;
  assign oe_fall = oe_q && !oe_n;
  assign op_end  = done || timeout;

  always_ff @(posedge clk) begin
    if (rst) begin
      nwr <= '0; lo_cnt <= '0; hi_cnt <= '0; gap_cnt <= '0; oeh_cnt <= '0;
      we_q <= 1'b1; oe_q <= 1'b1; rd_seen <= 1'b0; pg_q <= '0;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
      lo_cnt  <= we_n ? '0 : ((lo_cnt == CK_MAX) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt  <= !we_n ? '0 : ((hi_cnt == CK_MAX) ? hi_cnt : hi_cnt + 1'b1);
      oeh_cnt <= !oe_n ? '0 : ((oeh_cnt == CK_MAX) ? oeh_cnt : oeh_cnt + 1'b1);
      gap_cnt <= we_fall ? CK_W'(1) : ((gap_cnt == CK_MAX) ? gap_cnt : gap_cnt + 1'b1);
      if (op_end) nwr <= '0;
      else if (we_fall && nwr != 8'hFF) nwr <= nwr + 1'b1;
      if (op_end) rd_seen <= 1'b0;
      else if (oe_fall) rd_seen <= 1'b1;
      if (we_fall && nwr == 8'd3) pg_q <= addr[ADDR_W-1:OFS_W];
    end
  end

  // R1
  unlock_first_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(we_n) && nwr == 8'd0) |-> (addr == CMD_ADDR_A && dq_out == DATA_W'(8'hAA)));
  // R1
  unlock_second_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(we_n) && nwr == 8'd1) |-> (addr == CMD_ADDR_B && dq_out == DATA_W'(8'h55)));
  // R1
  unlock_third_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(we_n) && nwr == 8'd2) |-> (addr == CMD_ADDR_A && dq_out == DATA_W'(8'hA0)));
  // R3
  same_page_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(we_n) && nwr > 8'd3) |-> (addr[ADDR_W-1:OFS_W] == pg_q));
  // R4
  wr_strobe_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (oe_n && !ce_n && dq_oe));
  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(dq_out)));
  // R4
  wr_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (lo_cnt >= CK_W'(WP_CYC)));
  // R4
  wr_high_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(we_n) && nwr != 8'd0) |-> (hi_cnt >= CK_W'(WPH_CYC)));
  // R5
  byte_window_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(we_n) && nwr != 8'd0) |-> (gap_cnt < CK_W'(BLC_CYC)));
  // R7
  read_recovery_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(oe_n) && rd_seen) |-> (oeh_cnt >= CK_W'(OEH_CYC)));
  // R11
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (ce_n && oe_n && we_n && !dq_oe && !done && !timeout));
  // R12
  end_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R12
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);

endmodule

bind eeprom_page_prog eepg_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .OFS_W     (OFS_W),
  .WP_CYC    (WP_CYC),
  .WPH_CYC   (WPH_CYC),
  .OEH_CYC   (OEH_CYC),
  .CMD_ADDR_A(CMD_ADDR_A),
  .CMD_ADDR_B(CMD_ADDR_B)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .done   (done),
  .timeout(timeout),
  .ce_n   (ce_n),
  .oe_n   (oe_n),
  .we_n   (we_n),
  .addr   (addr),
  .dq_out (dq_out),
  .dq_oe  (dq_oe)
);

// File: tb/eeprom_page_prog_test.sv
module eeprom_page_prog_test;

  localparam int LIMIT = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [8:0]  page = '0;
  logic [6:0]  byte_count = '0;
  logic        poll_mode = 1'b0;
  logic        buf_we = 1'b0;
  logic [5:0]  buf_idx = '0;
  logic [7:0]  buf_wdata = '0;
  logic        done, timeout, ce_n, oe_n, we_n, dq_oe;
  logic [14:0] addr;
  logic [7:0]  dq_out, dq_in;

  always #10 clk = ~clk;

  eeprom_page_prog #(.POLL_LIMIT(LIMIT)) uut (
    .clk(clk), .rst(rst), .start(start), .page(page), .byte_count(byte_count),
    .poll_mode(poll_mode), .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .done(done), .timeout(timeout), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // Behavioural device: logs writes, reports busy status after the last one
  int          nlog = 0, nreads = 0, rd_bad = 0, busy_left = 0, busy_cfg = 0;
  int          n_done = 0, n_to = 0, cyc = 0;
  logic        hang = 1'b0, tog = 1'b0, prev_we = 1'b1, prev_oe = 1'b1;
  logic [14:0] log_a [0:511];
  logic [7:0]  log_d [0:511];
  logic [14:0] pa = '0, last_a = '0;
  logic [7:0]  pd = '0, last_d = '0;
  logic        mdl_busy;

  assign mdl_busy = hang || (busy_left > 0);
  assign dq_in = mdl_busy ? {~last_d[7], tog, last_d[5:0]} :
                 ((addr == last_a) ? last_d : 8'h00);

  always @(negedge clk) begin
    cyc++;
    if (done) n_done++;
    if (timeout) n_to++;
    if (!prev_we && we_n) begin
      if (nlog < 512) begin log_a[nlog] = pa; log_d[nlog] = pd; end
      nlog++;
      last_a = pa; last_d = pd; busy_left = busy_cfg;
    end else if (busy_left > 0) busy_left--;
    if (!we_n) begin pa = addr; pd = dq_out; end
    if (prev_oe && !oe_n) begin nreads++; if (addr != last_a) rd_bad++; end
    if (!prev_oe && oe_n && mdl_busy) tog = ~tog;
    prev_we = we_n; prev_oe = oe_n;
  end

  int total = 0, fails = 0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cyc > 150000) begin
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  task automatic fill(input logic [7:0] seed, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); buf_we = 1'b1; buf_idx = 6'(i); buf_wdata = pat(seed, i);
    end
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic pulse_start(input logic m, input logic [6:0] n, input logic [8:0] p);
    @(negedge clk); start = 1'b1; poll_mode = m; byte_count = n; page = p;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end(input int d0, input int t0);
    for (int k = 0; k < 40000 && n_done == d0 && n_to == t0; k++) @(negedge clk);
  endtask

  typedef struct packed {
    logic       mode;
    logic [6:0] cnt;
    logic [8:0] pg;
    logic [7:0] seed;
    logic [11:0] busy;
  } vec_t;

  localparam vec_t VEC [0:4] = '{
    '{1'b0, 7'd1,  9'h000, 8'h11, 12'd300},
    '{1'b1, 7'd64, 9'h1FF, 8'h80, 12'd500},
    '{1'b0, 7'd17, 9'h0A5, 8'h3C, 12'd200},
    '{1'b1, 7'd2,  9'h123, 8'hF0, 12'd150},
    '{1'b0, 7'd64, 9'h155, 8'h00, 12'd0}
  };

  initial begin
    int b_l, b_r, b_bad, d0, t0, c0, bad;
    vec_t tv;
    // R11: reset state
    repeat (4) @(negedge clk);
    chk(ce_n && oe_n && we_n && !dq_oe && !done && !timeout, "R11 reset idle",
        {ce_n, oe_n, we_n, dq_oe, done, timeout}, 6'b111000);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      tv = VEC[v];
      fill(tv.seed, int'(tv.cnt));
      busy_cfg = int'(tv.busy);
      b_l = nlog; b_r = nreads; b_bad = rd_bad; d0 = n_done; t0 = n_to;
      pulse_start(tv.mode, tv.cnt, tv.pg);
      if (v == 2) begin
        // R10: start while busy
        repeat (40) @(negedge clk);
        pulse_start(1'b1, 7'd5, 9'h000);
      end
      wait_end(d0, t0);
      chk(n_done == d0 + 1 && n_to == t0, tv.mode ? "R7 done seen" : "R6 done seen",
          n_done - d0, 1);
      chk(!mdl_busy, tv.mode ? "R7 done after ready" : "R6 done after ready", mdl_busy, 0);
      chk(rd_bad == b_bad && nreads > b_r, tv.mode ? "R7 fixed poll address" : "R6 poll address",
          rd_bad - b_bad, 0);
      chk(nlog - b_l == int'(tv.cnt) + 3, "R2 write count", nlog - b_l, int'(tv.cnt) + 3);
      chk(log_a[b_l] == 15'h5555 && log_d[b_l] == 8'hAA &&
          log_a[b_l+1] == 15'h2AAA && log_d[b_l+1] == 8'h55 &&
          log_a[b_l+2] == 15'h5555 && log_d[b_l+2] == 8'hA0,
          "R1 unlock sequence", {log_d[b_l], log_d[b_l+1], log_d[b_l+2]}, 24'hAA55A0);
      bad = 0;
      for (int i = 0; i < int'(tv.cnt); i++)
        if (log_a[b_l+3+i] != {tv.pg, 6'(i)} || log_d[b_l+3+i] != pat(tv.seed, i)) bad++;
      chk(bad == 0, "R2 R3 data bytes and page", bad, 0);
      repeat (3) @(negedge clk);
      chk(n_done == d0 + 1, v == 2 ? "R10 single done" : "R12 single done", n_done - d0, 1);
    end

    // R9: zero count
    b_l = nlog; b_r = nreads; d0 = n_done;
    pulse_start(1'b0, 7'd0, 9'h010);
    repeat (2) @(negedge clk);
    chk(n_done == d0 + 1 && nlog == b_l && nreads == b_r, "R9 zero count", n_done - d0, 1);
    // R9: count above page size
    b_l = nlog; b_r = nreads; d0 = n_done;
    pulse_start(1'b1, 7'd65, 9'h010);
    repeat (2) @(negedge clk);
    chk(n_done == d0 + 1 && nlog == b_l && nreads == b_r, "R9 oversize count", n_done - d0, 1);

    // R8: device never becomes ready
    fill(8'h42, 3);
    hang = 1'b1;
    b_l = nlog; d0 = n_done; t0 = n_to;
    pulse_start(1'b0, 7'd3, 9'h077);
    c0 = cyc;
    wait_end(d0, t0);
    chk(n_to == t0 + 1 && n_done == d0, "R8 timeout pulse", n_to - t0, 1);
    chk(cyc - c0 >= LIMIT && cyc - c0 <= LIMIT + 400, "R8 timeout latency", cyc - c0, LIMIT);
    chk(ce_n && oe_n && we_n && !dq_oe, "R8 bus idle after timeout",
        {ce_n, oe_n, we_n, dq_oe}, 4'b1110);
    repeat (3) @(negedge clk);
    chk(n_to == t0 + 1, "R12 single timeout", n_to - t0, 1);
    hang = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule